// File: doc/BRIEF.md
# Word-Swapping 16-Bit Host Bus Adapter

This block links a 16-bit host data bus to a 32-bit internal register port. A 32-bit write is made of two 16-bit host writes. The first half is held in a staging register, and the 32-bit word is committed only when the matching second half arrives. A 32-bit read is also made of two host reads. The first read takes a snapshot of the whole internal word, so the second read returns the other half of that same snapshot, even if the internal word has changed in between.

Host address bit A1 picks which half of the internal word an access touches. A 32-bit swap-control register sets the mapping:

- **Normal mode:** A1=0 is the low half, A1=1 is the high half, and A1=0 comes first.
- **Swap mode:** active only when every bit of the swap register is one. A1=1 is the low half and comes first, and A1=0 is the high half that completes the transfer.

In both modes the first access of a pair carries the low half. Each pair keeps the mode it started with, so a change of the swap register takes effect from the next pair onwards.

Host strobes are single-cycle pulses that are already synchronous to `clk`. All outputs are registered. Each host access shows its result in the cycle after the clock edge that samples the strobe.

Top module: `hba16_top`

## Requirements
- R1: After reset, `reg_we`, `reg_re`, `hst_rdata` and `swap_mode` are all zero, and the adapter is in normal mode.
- R2: `swap_mode` is 1 if and only if the last value written to the swap register is all ones (0xFFFFFFFF). Any other value, including one with a single zero bit, gives 0. The new value shows on `swap_mode` the cycle after the write.
- R3: In normal mode, a write with A1=0 followed by a write with A1=1 commits `{A1=1 data, A1=0 data}`. So A1=0 is bits 15:0 and A1=1 is bits 31:16.
- R4: In swap mode, a write with A1=1 followed by a write with A1=0 commits `{A1=0 data, A1=1 data}`. So on A1=0 the upper data byte carries byte 3 and the lower carries byte 2, and on A1=1 they carry bytes 1 and 0.
- R5: `reg_we` pulses for exactly one cycle, the cycle after the second-half write. A first-half write alone never raises `reg_we`.
- R6: A second-half write with no staged first half is dropped: it causes no commit.
- R7: A repeated first-half write replaces the staged half, and the later commit uses the newest first half.
- R8: A first-half read returns the low half of `reg_rdata` and pulses `reg_re` for one cycle. The following second-half read returns the high half of the word captured at the first read, with no `reg_re` pulse.
- R9: A second-half read with no snapshot pending returns the high half of the current `reg_rdata` and does not pulse `reg_re`.
- R10: A write to the swap register while a write or read pair is open does not change that pair's mapping. The next pair uses the new mode.
- R11: `hst_rdata` holds its value in cycles without a host read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_wr | input | 1 | Host write strobe, one cycle per access |
| hst_rd | input | 1 | Host read strobe, one cycle per access |
| hst_a1 | input | 1 | Host address bit selecting the half |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data, valid the cycle after the read strobe |
| swap_we | input | 1 | Write strobe for the swap-control register |
| swap_wdata | input | 32 | New swap-control value |
| swap_mode | output | 1 | 1 when the swap register holds all ones |
| reg_we | output | 1 | Internal 32-bit write pulse |
| reg_wdata | output | 32 | Internal 32-bit write word |
| reg_re | output | 1 | Pulse marking that an internal word was captured for reading |
| reg_rdata | input | 32 | Current internal 32-bit read word |

## Verification
The hardest case to reach is a swap-register write that lands between the two halves of an open pair. The old mode must then govern the second half, and the new mode must govern the pair that follows. The bench opens a pair, changes the swap register, and completes the pair with the A1 value that the old mode expects, on both the write side and the read side. It then runs a full pair in the new order. The snapshot rule is exercised by changing `reg_rdata` between the two reads of a pair. The exact-all-ones decode is swept over every single-bit-cleared value.

// File: rtl/hba_pkg.sv
package hba_pkg;
  // State of an open half-word pair: whether a first half is held, and the
  // mode (0 normal, 1 swapped) captured when that first half arrived.
  typedef struct packed {
    logic open;
    logic mode;
  } pair_t;

  // A1 value that opens a pair under a given mode: 0 when normal, 1 when swapped.
  function automatic logic opener_a1(input logic mode);
    return mode;
  endfunction
endpackage

// File: rtl/hba_swap_ctl.sv
module hba_swap_ctl #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              swap_we,
  input  logic [WORD_W-1:0] swap_wdata,
  output logic              swap_mode
);
  logic [WORD_W-1:0] ctl_q;

  always_ff @(posedge clk) begin
    if (rst)          ctl_q <= '0;
    else if (swap_we) ctl_q <= swap_wdata;
  end

  // Only the exact all-ones pattern enables swapping.
  assign swap_mode = &ctl_q;

  a_r2_decode: assert property (@(posedge clk) disable iff (rst)
    swap_we |=> (swap_mode == ($past(swap_wdata) == {WORD_W{1'b1}})));
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !swap_we |=> $stable(swap_mode));
endmodule

// File: rtl/hba_wr_asm.sv
module hba_wr_asm
  import hba_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode,
  input  logic              wr,
  input  logic              a1,
  input  logic [HALF_W-1:0] wdata,
  output logic              reg_we,
  output logic [WORD_W-1:0] reg_wdata
);
  pair_t             st_q;
  logic [HALF_W-1:0] stage_q;
  logic              open_hit;
  logic              close_hit;

  // An open pair keeps its captured mode; an idle adapter follows the live mode.
  assign open_hit  = wr && (a1 == opener_a1(st_q.open ? st_q.mode : mode));
  assign close_hit = wr && st_q.open && (a1 != opener_a1(st_q.mode));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= '0;
      stage_q   <= '0;
      reg_we    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_we <= close_hit;
      if (open_hit) begin
        stage_q    <= wdata;
        st_q.open  <= 1'b1;
        if (!st_q.open) st_q.mode <= mode;
      end else if (close_hit) begin
        reg_wdata <= {wdata, stage_q};
        st_q.open <= 1'b0;
      end
    end
  end

  a_r5_commit: assert property (@(posedge clk) disable iff (rst)
    close_hit |=> (reg_we && reg_wdata == {$past(wdata), $past(stage_q)}));
  a_r5_needs_stage: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> $past(st_q.open));
  a_r6_orphan_dropped: assert property (@(posedge clk) disable iff (rst)
    (wr && !st_q.open && a1 != opener_a1(mode)) |=> !reg_we);
  a_r10_mode_kept: assert property (@(posedge clk) disable iff (rst)
    (st_q.open && !close_hit) |=> $stable(st_q.mode));
endmodule

// File: rtl/hba_rd_snap.sv
module hba_rd_snap
  import hba_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode,
  input  logic              rd,
  input  logic              a1,
  input  logic [WORD_W-1:0] reg_rdata,
  output logic              reg_re,
  output logic [HALF_W-1:0] hst_rdata
);
  pair_t             st_q;
  logic [WORD_W-1:0] snap_q;
  logic              open_hit;
  logic              close_hit;

  assign open_hit  = rd && (a1 == opener_a1(st_q.open ? st_q.mode : mode));
  assign close_hit = rd && st_q.open && (a1 != opener_a1(st_q.mode));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= '0;
      snap_q    <= '0;
      reg_re    <= 1'b0;
      hst_rdata <= '0;
    end else begin
      reg_re <= open_hit;
      if (open_hit) begin
        snap_q     <= reg_rdata;
        hst_rdata  <= reg_rdata[HALF_W-1:0];
        st_q.open  <= 1'b1;
        if (!st_q.open) st_q.mode <= mode;
      end else if (close_hit) begin
        hst_rdata <= snap_q[WORD_W-1:HALF_W];
        st_q.open <= 1'b0;
      end else if (rd) begin
        // High half requested with nothing captured: serve the live word.
        hst_rdata <= reg_rdata[WORD_W-1:HALF_W];
      end
    end
  end

  a_r8_first: assert property (@(posedge clk) disable iff (rst)
    open_hit |=> (reg_re && hst_rdata == $past(reg_rdata[HALF_W-1:0])));
  a_r8_second: assert property (@(posedge clk) disable iff (rst)
    close_hit |=> (!reg_re && hst_rdata == $past(snap_q[WORD_W-1:HALF_W])));
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(hst_rdata));
endmodule

// File: rtl/hba16_top.sv
module hba16_top #(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hst_wr,
  input  logic              hst_rd,
  input  logic              hst_a1,
  input  logic [HALF_W-1:0] hst_wdata,
  output logic [HALF_W-1:0] hst_rdata,
  input  logic              swap_we,
  input  logic [WORD_W-1:0] swap_wdata,
  output logic              swap_mode,
  output logic              reg_we,
  output logic [WORD_W-1:0] reg_wdata,
  output logic              reg_re,
  input  logic [WORD_W-1:0] reg_rdata
);
  hba_swap_ctl #(.WORD_W(WORD_W)) u_swap (
    .clk        (clk),
    .rst        (rst),
    .swap_we    (swap_we),
    .swap_wdata (swap_wdata),
    .swap_mode  (swap_mode)
  );

  hba_wr_asm #(.HALF_W(HALF_W)) u_wr (
    .clk       (clk),
    .rst       (rst),
    .mode      (swap_mode),
    .wr        (hst_wr),
    .a1        (hst_a1),
    .wdata     (hst_wdata),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata)
  );

  hba_rd_snap #(.HALF_W(HALF_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .mode      (swap_mode),
    .rd        (hst_rd),
    .a1        (hst_a1),
    .reg_rdata (reg_rdata),
    .reg_re    (reg_re),
    .hst_rdata (hst_rdata)
  );

  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!reg_we && !reg_re && !swap_mode && hst_rdata == '0));
endmodule

// File: tb/hba16_top_bench.sv
module hba16_top_bench;
  localparam int HW = 16;
  localparam int WW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hst_wr = 1'b0, hst_rd = 1'b0, hst_a1 = 1'b0;
  logic [HW-1:0] hst_wdata = '0;
  logic [HW-1:0] hst_rdata;
  logic          swap_we = 1'b0;
  logic [WW-1:0] swap_wdata = '0;
  logic          swap_mode;
  logic          reg_we, reg_re;
  logic [WW-1:0] reg_wdata;
  logic [WW-1:0] reg_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  hba16_top u_hba16_top (
    .clk(clk), .rst(rst), .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_a1(hst_a1),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .swap_we(swap_we),
    .swap_wdata(swap_wdata), .swap_mode(swap_mode), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [WW-1:0] act,
                     input logic [WW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_swap(input logic [WW-1:0] v);
    @(negedge clk); swap_we = 1'b1; swap_wdata = v;
    @(negedge clk); swap_we = 1'b0;
  endtask

  // One host write; returns outputs seen in the cycle after the edge.
  task automatic hwr(input logic a1, input logic [HW-1:0] d,
                     output logic we, output logic [WW-1:0] w);
    @(negedge clk); hst_wr = 1'b1; hst_a1 = a1; hst_wdata = d;
    @(negedge clk); hst_wr = 1'b0;
    we = reg_we; w = reg_wdata;
  endtask

  task automatic hrd(input logic a1, output logic [HW-1:0] d, output logic re);
    @(negedge clk); hst_rd = 1'b1; hst_a1 = a1;
    @(negedge clk); hst_rd = 1'b0;
    d = hst_rdata; re = reg_re;
  endtask

  initial begin
    #4000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic          we, re;
    logic [WW-1:0] w;
    logic [HW-1:0] d;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!reg_we && !reg_re && !swap_mode && hst_rdata == '0, "R1 reset",
        {reg_we, reg_re, swap_mode, hst_rdata}, '0);

    // R2: exact all-ones decode, every single-bit-cleared value rejected
    set_swap('1);
    chk(swap_mode == 1'b1, "R2 all ones", 32'(swap_mode), 1);
    for (int i = 0; i < WW; i++) begin
      set_swap(~(32'd1 << i));
      chk(swap_mode == 1'b0, "R2 one bit clear", 32'(swap_mode), 0);
    end
    set_swap('0);
    chk(swap_mode == 1'b0, "R2 zero", 32'(swap_mode), 0);

    // R3 / R5: normal ordering
    for (int k = 0; k < 8; k++) begin
      logic [HW-1:0] lo, hi;
      lo = 16'(k * 16'h1357 + 16'h0101);
      hi = ~lo ^ 16'(k << 4);
      hwr(1'b0, lo, we, w);
      chk(!we, "R5 no commit on first half", 32'(we), 0);
      hwr(1'b1, hi, we, w);
      chk(we && w == {hi, lo}, "R3 normal commit", w, {hi, lo});
      @(negedge clk);
      chk(!reg_we, "R5 single pulse", 32'(reg_we), 0);
    end

    // R4: swap ordering and byte lanes
    set_swap('1);
    for (int k = 0; k < 8; k++) begin
      logic [HW-1:0] b10, b32;
      b10 = 16'(k * 16'h0202 + 16'h0100);
      b32 = 16'(k * 16'h0202 + 16'h0302);
      hwr(1'b1, b10, we, w);
      chk(!we, "R4 swap first half held", 32'(we), 0);
      hwr(1'b0, b32, we, w);
      chk(we && w == {b32, b10}, "R4 swap commit", w, {b32, b10});
    end

    // R6: orphan second halves in both modes
    hwr(1'b0, 16'hDEAD, we, w);
    chk(!we, "R6 orphan swap", 32'(we), 0);
    set_swap('0);
    hwr(1'b1, 16'hBEEF, we, w);
    chk(!we, "R6 orphan normal", 32'(we), 0);

    // R7: restaged first half
    hwr(1'b0, 16'h1111, we, w);
    hwr(1'b0, 16'h2222, we, w);
    hwr(1'b1, 16'h3333, we, w);
    chk(we && w == 32'h3333_2222, "R7 restage", w, 32'h3333_2222);

    // R8: normal read snapshot
    reg_rdata = 32'hA1B2_C3D4;
    hrd(1'b0, d, re);
    chk(re && d == 16'hC3D4, "R8 first read normal", {15'd0, re, d}, {16'd1, 16'hC3D4});
    reg_rdata = 32'h5566_7788;
    hrd(1'b1, d, re);
    chk(!re && d == 16'hA1B2, "R8 second from snapshot", {15'd0, re, d}, {16'd0, 16'hA1B2});
    // R11
    repeat (3) @(negedge clk);
    chk(hst_rdata == 16'hA1B2, "R11 hold", 32'(hst_rdata), 32'hA1B2);

    // R9: orphan high read returns live word
    hrd(1'b1, d, re);
    chk(!re && d == 16'h5566, "R9 live high", {15'd0, re, d}, {16'd0, 16'h5566});

    // R8 in swap mode
    set_swap('1);
    reg_rdata = 32'h0A0B_0C0D;
    hrd(1'b1, d, re);
    chk(re && d == 16'h0C0D, "R8 first read swap", {15'd0, re, d}, {16'd1, 16'h0C0D});
    reg_rdata = 32'hFFFF_0000;
    hrd(1'b0, d, re);
    chk(!re && d == 16'h0A0B, "R8 second read swap", {15'd0, re, d}, {16'd0, 16'h0A0B});

    // R10: mode change inside an open write pair and read pair
    set_swap('0);
    hwr(1'b0, 16'h4444, we, w);
    set_swap('1);
    hwr(1'b1, 16'h5555, we, w);
    chk(we && w == 32'h5555_4444, "R10 write pair keeps normal", w, 32'h5555_4444);
    hwr(1'b1, 16'h6666, we, w);
    chk(!we, "R10 next pair swap first", 32'(we), 0);
    hwr(1'b0, 16'h7777, we, w);
    chk(we && w == 32'h7777_6666, "R10 next pair swap", w, 32'h7777_6666);

    reg_rdata = 32'h1234_5678;
    hrd(1'b1, d, re);
    set_swap('0);
    hrd(1'b0, d, re);
    chk(!re && d == 16'h1234, "R10 read pair keeps swap", {15'd0, re, d}, {16'd0, 16'h1234});
    hrd(1'b0, d, re);
    chk(re && d == 16'h5678, "R10 next read pair normal", {15'd0, re, d}, {16'd1, 16'h5678});
    hrd(1'b1, d, re);
    chk(d == 16'h1234, "R10 next read pair high", 32'(d), 32'h1234);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule